// File: doc/BRIEF.md
# Framebuffer Controller Register Interface

This block is the memory-mapped control front end of an 8-bit indexed framebuffer controller. A host issues single accesses on a 32-bit bus. Each access carries a byte address, a read/write flag and a size of byte, halfword or word. The block decodes a sparse 21-bit offset space into five groups:

- an identifier word;
- scalar display registers: horizontal size, vertical size, the control word, the screen start offset and the cursor position;
- a cursor colour table of three entries, held locally;
- a 256-entry colour lookup window and a 512-entry cursor bitmap window, both steered to external memories through strobes;
- a soft-reset location.

The block presents the decoded state to the pixel path as plain outputs: width in pixels, height in lines, start offset, cursor coordinates and enable, a blank request, the pixel depth in bits and the cursor colours.

Every access runs as a short fixed sequence. The request is captured first. In the second cycle the containing 32-bit word is fetched, and for the cursor bitmap this is a read strobe to the external memory. In the third cycle the access commits. A byte or halfword write merges its bytes into the fetched word and then commits that word as a full write. A byte or halfword read returns its lane shifted down to bit 0.

The block also owns the frame interrupt. A one-cycle frame-done pulse from the display path sets the interrupt, and any committed write clears it.

Top module: `fbctl_regs`

## Requirements
- R1: An access is accepted on a rising edge where `req_i` and `ready_o` are both high. `ready_o` then drops, and `done_o` is high for exactly one cycle, starting on the second rising edge after acceptance. Read data and `err_o` are valid while `done_o` is high. State changes take effect on the edge that ends the `done_o` cycle, and `ready_o` returns high on that same edge.
- R2: A read of word offset 0x000000 returns 0x10. Writes to that offset change nothing and raise no error.
- R3: A write to offset 0x080118 sets the width to four times the written value, truncated to DIM_W bits. A read of that offset returns the width divided by four.
- R4: A write to offset 0x080150 sets the height to the written value halved. A read of that offset returns twice the height.
- R5: Offset 0x080300 holds a 32-bit control word that reads back unchanged. Control bits 22:20 select the depth: codes 0 to 5 give 1, 2, 4, 8, 15 and 16 bits, and codes 6 and 7 give 0. Control bit 10 drives `blank_o`. Control bit 23 set clears `cursor_en_o`.
- R6: Table entries are 8 bytes apart, so the entry index is (offset − window base) >> 3. The cursor colour table has 3 entries at 0x080508 and reads back as {8'h00, 24-bit colour}. The colour lookup window has 256 entries at 0x080800. It is write-only: `pal_we_o` pulses with the index and the low 24 bits. The cursor bitmap window has 512 entries at 0x081000. A write pulses `pat_we_o` with the low 16 bits. A read pulses `pat_re_o` in the cycle before `done_o`, and the returned 16 bits appear zero-extended.
- R7: A write to 0x080400 sets `top_o`. A write to 0x080638 sets the cursor position: x is taken from bits 23:12 and y from bits 11:0. Both offsets are write-only.
- R8: Writes to the video timing offsets are accepted with no effect and no error. These offsets are 0x080000, 0x080108 to 0x080148 and 0x080158 to 0x080170 in steps of 8, and 0x080200.
- R9: A write to 0x180000 clears width, height, control, start offset, cursor position and the cursor colour table. It also pulses `mem_clr_o` for the external tables.
- R10: A byte write (size 0) or halfword write (size 1) takes its data from the low bits of `wdata_i`. It replaces the lane chosen by address bits 1:0 (byte) or bit 1 (halfword) in the word currently read at that offset, then commits the merged word. Write-only and colour lookup offsets read as zero for this merge.
- R11: A byte or halfword read returns the selected lane of the containing word, shifted to bit 0, with the upper bits zero. Size 2 is a word access.
- R12: A read of any offset that is not readable returns 0 and raises `err_o` during `done_o`. A write to an offset that matches no group also raises `err_o` and changes no state.
- R13: A `frame_done_i` pulse sets `irq_o`. Any committed write clears `irq_o`. If a write commits on the same edge as `frame_done_i`, `irq_o` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| addr_i | input | 21 | Byte offset |
| wdata_i | input | 32 | Write data, low-aligned for sub-word sizes |
| ready_o | output | 1 | Idle, a request may be accepted |
| done_o | output | 1 | Access commit cycle |
| rdata_o | output | 32 | Read data, valid with done_o |
| err_o | output | 1 | Undefined or unreadable offset, valid with done_o |
| frame_done_i | input | 1 | One-cycle end-of-frame pulse |
| irq_o | output | 1 | Frame interrupt |
| width_o | output | DIM_W | Width in pixels |
| height_o | output | DIM_W | Height in lines |
| top_o | output | 32 | Screen start offset |
| cursor_x_o | output | 12 | Cursor x |
| cursor_y_o | output | 12 | Cursor y |
| cursor_en_o | output | 1 | Cursor shown |
| blank_o | output | 1 | Forced blanking |
| depth_o | output | 5 | Pixel depth in bits |
| cur_pal_o | output | 72 | Three cursor colours, entry 0 in bits 23:0 |
| pal_we_o | output | 1 | Colour lookup write strobe |
| pal_idx_o | output | 8 | Colour lookup index |
| pal_wdata_o | output | 24 | Colour lookup data |
| pat_re_o | output | 1 | Cursor bitmap read strobe |
| pat_we_o | output | 1 | Cursor bitmap write strobe |
| pat_idx_o | output | 9 | Cursor bitmap index |
| pat_wdata_o | output | 16 | Cursor bitmap write data |
| pat_rdata_i | input | 16 | Cursor bitmap read data, one cycle after pat_re_o |
| mem_clr_o | output | 1 | Clear external tables |

## Verification
The bench aims at the scaling edges. These are a width value whose fourfold overflows DIM_W, and an odd height value, which loses its low bit on readback. A design that stored raw values or rounded the wrong way would read back the wrong number. Sub-word writes to the cursor bitmap and to the colour table probe the read-modify-write merge. A design that zeroed the other lanes, or skipped the fetch from the external memory, would corrupt the neighbouring bytes. Further checks cover the two addresses that fall into one 8-byte entry, a write to an ignored timing offset, a read of a write-only offset, and a write that lands on the same edge as a frame pulse. Errors there show up as a wrong table entry, a stray error flag, a changed register or a lost interrupt.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;
  localparam int unsigned ADDR_W = 21;
  localparam int unsigned STRIDE_SH = 3;

  localparam logic [ADDR_W-1:0] OFF_ID    = 21'h000000;
  localparam logic [ADDR_W-1:0] OFF_HDISP = 21'h080118;
  localparam logic [ADDR_W-1:0] OFF_VDISP = 21'h080150;
  localparam logic [ADDR_W-1:0] OFF_CTL   = 21'h080300;
  localparam logic [ADDR_W-1:0] OFF_TOP   = 21'h080400;
  localparam logic [ADDR_W-1:0] OFF_CPAL  = 21'h080508;
  localparam logic [ADDR_W-1:0] OFF_CPOS  = 21'h080638;
  localparam logic [ADDR_W-1:0] OFF_PAL   = 21'h080800;
  localparam logic [ADDR_W-1:0] OFF_PAT   = 21'h081000;
  localparam logic [ADDR_W-1:0] OFF_SWRST = 21'h180000;

  localparam int unsigned CPAL_SPAN = 32'h18;
  localparam int unsigned PAL_SPAN  = 32'h800;
  localparam int unsigned PAT_SPAN  = 32'h1000;
  localparam int unsigned CPAL_N    = CPAL_SPAN >> STRIDE_SH;
  localparam int unsigned PAL_N     = PAL_SPAN >> STRIDE_SH;
  localparam int unsigned PAT_N     = PAT_SPAN >> STRIDE_SH;
  localparam int unsigned PAL_IDX_W = $clog2(PAL_N);
  localparam int unsigned PAT_IDX_W = $clog2(PAT_N);
  localparam int unsigned COLOR_W   = 24;
  localparam int unsigned PAT_W     = 16;

  localparam logic [31:0] ID_VALUE = 32'h0000_0010;

  localparam int unsigned CTL_BLANK_BIT = 10;
  localparam int unsigned CTL_NOCUR_BIT = 23;
  localparam int unsigned CTL_DEPTH_LSB = 20;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [3:0] {
    RG_NONE, RG_ID, RG_HDISP, RG_VDISP, RG_CTL, RG_TOP, RG_CPOS,
    RG_CPAL, RG_PAL, RG_PAT, RG_TIMING, RG_SWRST
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_FETCH, ST_COMMIT
  } acc_state_e;
endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
  import fbctl_pkg::*;
(
  input  logic [ADDR_W-1:2]    waddr_i,
  output region_e              region_o,
  output logic [PAT_IDX_W-1:0] idx_o
);
  logic [ADDR_W-1:0] off;
  assign off = {waddr_i, 2'b00};

  always_comb begin
    region_o = RG_NONE;
    idx_o    = '0;
    if (off >= OFF_PAL && off < OFF_PAL + ADDR_W'(PAL_SPAN)) begin
      region_o = RG_PAL;
      idx_o    = PAT_IDX_W'(off[STRIDE_SH +: PAL_IDX_W]);
    end else if (off >= OFF_PAT && off < OFF_PAT + ADDR_W'(PAT_SPAN)) begin
      region_o = RG_PAT;
      idx_o    = off[STRIDE_SH +: PAT_IDX_W];
    end else if (off >= OFF_CPAL && off < OFF_CPAL + ADDR_W'(CPAL_SPAN)) begin
      region_o = RG_CPAL;
      // base sits one stride above a 32-byte boundary
      idx_o    = PAT_IDX_W'(off[4:3] - 2'd1);
    end else begin
      unique case (off)
        OFF_ID:    region_o = RG_ID;
        OFF_HDISP: region_o = RG_HDISP;
        OFF_VDISP: region_o = RG_VDISP;
        OFF_CTL:   region_o = RG_CTL;
        OFF_TOP:   region_o = RG_TOP;
        OFF_CPOS:  region_o = RG_CPOS;
        OFF_SWRST: region_o = RG_SWRST;
        21'h080000, 21'h080108, 21'h080110, 21'h080120, 21'h080128,
        21'h080130, 21'h080138, 21'h080140, 21'h080148, 21'h080158,
        21'h080160, 21'h080168, 21'h080170, 21'h080200:
                   region_o = RG_TIMING;
        default:   region_o = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fbctl_lane.sv
module fbctl_lane
  import fbctl_pkg::*;
(
  input  logic [1:0]  size_i,
  input  logic [1:0]  lane_i,
  input  logic [31:0] old_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] merged_o,
  output logic [31:0] extract_o
);
  always_comb begin
    merged_o  = old_i;
    extract_o = old_i;
    unique case (acc_size_e'(size_i))
      SZ_BYTE: begin
        merged_o[8*lane_i +: 8] = wdata_i[7:0];
        extract_o = {24'h0, old_i[8*lane_i +: 8]};
      end
      SZ_HALF: begin
        merged_o[16*lane_i[1] +: 16] = wdata_i[15:0];
        extract_o = {16'h0, old_i[16*lane_i[1] +: 16]};
      end
      default: begin
        merged_o  = wdata_i;
        extract_o = old_i;
      end
    endcase
  end
endmodule

// File: rtl/fbctl_depth.sv
module fbctl_depth (
  input  logic [2:0] code_i,
  output logic [4:0] depth_o
);
  always_comb begin
    unique case (code_i)
      3'd0:    depth_o = 5'd1;
      3'd1:    depth_o = 5'd2;
      3'd2:    depth_o = 5'd4;
      3'd3:    depth_o = 5'd8;
      3'd4:    depth_o = 5'd15;
      3'd5:    depth_o = 5'd16;
      default: depth_o = 5'd0;
    endcase
  end
endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
  import fbctl_pkg::*;
#(
  parameter int unsigned DIM_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [1:0]                  size_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [31:0]                 wdata_i,
  output logic                        ready_o,
  output logic                        done_o,
  output logic [31:0]                 rdata_o,
  output logic                        err_o,
  input  logic                        frame_done_i,
  output logic                        irq_o,
  output logic [DIM_W-1:0]            width_o,
  output logic [DIM_W-1:0]            height_o,
  output logic [31:0]                 top_o,
  output logic [11:0]                 cursor_x_o,
  output logic [11:0]                 cursor_y_o,
  output logic                        cursor_en_o,
  output logic                        blank_o,
  output logic [4:0]                  depth_o,
  output logic [CPAL_N*COLOR_W-1:0]   cur_pal_o,
  output logic                        pal_we_o,
  output logic [PAL_IDX_W-1:0]        pal_idx_o,
  output logic [COLOR_W-1:0]          pal_wdata_o,
  output logic                        pat_re_o,
  output logic                        pat_we_o,
  output logic [PAT_IDX_W-1:0]        pat_idx_o,
  output logic [PAT_W-1:0]            pat_wdata_o,
  input  logic [PAT_W-1:0]            pat_rdata_i,
  output logic                        mem_clr_o
);
  localparam int unsigned POS_W = 24;

  acc_state_e          state_q;
  logic                req_we_q;
  logic [1:0]          size_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [31:0]         wdata_q;

  logic [DIM_W-1:0]    width_q, height_q;
  logic [31:0]         ctl_q, top_q;
  logic [POS_W-1:0]    cpos_q;
  logic [COLOR_W-1:0]  cpal_q [CPAL_N];
  logic                irq_q;

  region_e             region;
  logic [PAT_IDX_W-1:0] idx;
  logic [31:0]         old_word, merged, extracted;
  logic                readable, commit, wr, swrst;

  // request capture and access sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      req_we_q <= 1'b0;
      size_q   <= 2'd0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q  <= ST_FETCH;
          req_we_q <= we_i;
          size_q   <= size_i;
          addr_q   <= addr_i;
          wdata_q  <= wdata_i;
        end
        ST_FETCH:  state_q <= ST_COMMIT;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  fbctl_decode u_decode (
    .waddr_i  (addr_q[ADDR_W-1:2]),
    .region_o (region),
    .idx_o    (idx)
  );

  always_comb begin
    old_word = '0;
    readable = 1'b1;
    unique case (region)
      RG_ID:    old_word = ID_VALUE;
      RG_HDISP: old_word = 32'(width_q >> 2);
      RG_VDISP: old_word = 32'(height_q) << 1;
      RG_CTL:   old_word = ctl_q;
      RG_CPAL:  old_word = 32'(cpal_q[idx[1:0]]);
      RG_PAT:   old_word = 32'(pat_rdata_i);
      default:  readable = 1'b0;
    endcase
  end

  fbctl_lane u_lane (
    .size_i    (size_q),
    .lane_i    (addr_q[1:0]),
    .old_i     (old_word),
    .wdata_i   (wdata_q),
    .merged_o  (merged),
    .extract_o (extracted)
  );

  assign commit = (state_q == ST_COMMIT);
  assign wr     = commit && req_we_q;
  assign swrst  = wr && (region == RG_SWRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q  <= '0;
      height_q <= '0;
      ctl_q    <= '0;
      top_q    <= '0;
      cpos_q   <= '0;
    end else if (swrst) begin
      width_q  <= '0;
      height_q <= '0;
      ctl_q    <= '0;
      top_q    <= '0;
      cpos_q   <= '0;
    end else if (wr) begin
      unique case (region)
        RG_HDISP: width_q  <= {merged[DIM_W-3:0], 2'b00};
        RG_VDISP: height_q <= merged[DIM_W:1];
        RG_CTL:   ctl_q    <= merged;
        RG_TOP:   top_q    <= merged;
        RG_CPOS:  cpos_q   <= merged[POS_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < CPAL_N; g++) begin : g_cpal
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cpal_q[g] <= '0;
      else if (swrst)
        cpal_q[g] <= '0;
      else if (wr && region == RG_CPAL && idx[1:0] == 2'(g))
        cpal_q[g] <= merged[COLOR_W-1:0];
    end
    assign cur_pal_o[g*COLOR_W +: COLOR_W] = cpal_q[g];
  end

  // frame pulse wins over a same-edge write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           irq_q <= 1'b0;
    else if (frame_done_i) irq_q <= 1'b1;
    else if (wr)           irq_q <= 1'b0;
  end

  fbctl_depth u_depth (
    .code_i  (ctl_q[CTL_DEPTH_LSB +: 3]),
    .depth_o (depth_o)
  );

  assign ready_o     = (state_q == ST_IDLE);
  assign done_o      = commit;
  assign rdata_o     = (commit && !req_we_q && readable) ? extracted : '0;
  assign err_o       = commit && (req_we_q ? (region == RG_NONE) : !readable);
  assign irq_o       = irq_q;
  assign width_o     = width_q;
  assign height_o    = height_q;
  assign top_o       = top_q;
  assign cursor_x_o  = cpos_q[23:12];
  assign cursor_y_o  = cpos_q[11:0];
  assign cursor_en_o = !ctl_q[CTL_NOCUR_BIT];
  assign blank_o     = ctl_q[CTL_BLANK_BIT];
  assign pal_we_o    = wr && (region == RG_PAL);
  assign pal_idx_o   = idx[PAL_IDX_W-1:0];
  assign pal_wdata_o = merged[COLOR_W-1:0];
  assign pat_re_o    = (state_q == ST_FETCH) && (region == RG_PAT);
  assign pat_we_o    = wr && (region == RG_PAT);
  assign pat_idx_o   = idx;
  assign pat_wdata_o = merged[PAT_W-1:0];
  assign mem_clr_o   = swrst;
endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk #(
  parameter int unsigned DIM_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             ready_o,
  input logic             done_o,
  input logic             err_o,
  input logic             we_q,
  input logic             frame_done_i,
  input logic             irq_o,
  input logic             pal_we_o,
  input logic             pat_we_o,
  input logic             mem_clr_o,
  input logic [DIM_W-1:0] width_o,
  input logic [DIM_W-1:0] height_o,
  input logic [4:0]       depth_o
);
  p_accept_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o |=> ##1 done_o);
  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && ready_o);
  p_irq_set_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> irq_o);
  p_irq_clr_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && we_q && !frame_done_i |=> !irq_o);
  p_irq_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_i && !(done_o && we_q) |=> $stable(irq_o));
  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pal_we_o, pat_we_o, mem_clr_o}));
  p_strobe_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pal_we_o || pat_we_o || mem_clr_o) |-> done_o && we_q);
  p_swrst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_clr_o |=> width_o == '0 && height_o == '0);
  p_err_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  always @(posedge clk_i) begin
    if (rst_ni) begin
      p_depth_set_r5: assert (depth_o inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16});
    end
  end
endmodule

bind fbctl_regs fbctl_regs_chk #(.DIM_W(DIM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .ready_o      (ready_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .we_q         (req_we_q),
  .frame_done_i (frame_done_i),
  .irq_o        (irq_o),
  .pal_we_o     (pal_we_o),
  .pat_we_o     (pat_we_o),
  .mem_clr_o    (mem_clr_o),
  .width_o      (width_o),
  .height_o     (height_o),
  .depth_o      (depth_o)
);

// File: tb/tb_fbctl_regs.sv
module tb_fbctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int DIM_W = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0, frame_done = 1'b0;
  logic [1:0] size = 2'd2;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0;
  logic ready, done, err, irq, cursor_en, blank, pal_we, pat_re, pat_we, mem_clr;
  logic [31:0] rdata, top;
  logic [DIM_W-1:0] width, height;
  logic [11:0] cx, cy;
  logic [4:0] depth;
  logic [71:0] cur_pal;
  logic [7:0] pal_idx;
  logic [23:0] pal_wdata;
  logic [8:0] pat_idx;
  logic [15:0] pat_wdata;
  logic [15:0] pat_rdata = '0;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbctl_regs #(.DIM_W(DIM_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .err_o(err), .frame_done_i(frame_done), .irq_o(irq),
    .width_o(width), .height_o(height), .top_o(top), .cursor_x_o(cx),
    .cursor_y_o(cy), .cursor_en_o(cursor_en), .blank_o(blank), .depth_o(depth),
    .cur_pal_o(cur_pal), .pal_we_o(pal_we), .pal_idx_o(pal_idx),
    .pal_wdata_o(pal_wdata), .pat_re_o(pat_re), .pat_we_o(pat_we),
    .pat_idx_o(pat_idx), .pat_wdata_o(pat_wdata), .pat_rdata_i(pat_rdata),
    .mem_clr_o(mem_clr)
  );

  // external bitmap memory and colour-table capture
  logic [15:0] pat_mem [512];
  logic pal_seen = 1'b0;
  logic [7:0] pal_seen_idx = '0;
  logic [23:0] pal_seen_data = '0;
  logic clr_seen = 1'b0;

  always @(posedge clk) begin
    if (pat_re) pat_rdata <= pat_mem[pat_idx];
    if (pat_we) pat_mem[pat_idx] <= pat_wdata;
    if (mem_clr) begin
      for (int i = 0; i < 512; i++) pat_mem[i] <= '0;
      clr_seen <= 1'b1;
    end
    if (pal_we) begin
      pal_seen <= 1'b1;
      pal_seen_idx <= pal_idx;
      pal_seen_data <= pal_wdata;
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge_f(logic [31:0] old, logic [31:0] wd,
                                          logic [1:0] sz, logic [1:0] ln);
    logic [31:0] m = old;
    if (sz == 2'd0) m[8*ln +: 8] = wd[7:0];
    else if (sz == 2'd1) m[16*ln[1] +: 16] = wd[15:0];
    else m = wd;
    return m;
  endfunction

  function automatic logic [31:0] extract_f(logic [31:0] w, logic [1:0] sz, logic [1:0] ln);
    if (sz == 2'd0) return {24'h0, w[8*ln +: 8]};
    if (sz == 2'd1) return {16'h0, w[16*ln[1] +: 16]};
    return w;
  endfunction

  logic [31:0] r_data;
  logic r_err, r_done;

  // starts and ends on a falling edge
  task automatic access(input logic w, input logic [20:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic fd);
    req = 1'b1; we = w; addr = a; size = sz; wdata = d;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    r_done = done; r_data = rdata; r_err = err;
    if (fd) frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic wr(input logic [20:0] a, input logic [1:0] sz, input logic [31:0] d);
    access(1'b1, a, sz, d, 1'b0);
  endtask

  task automatic rd(input logic [20:0] a, input logic [1:0] sz);
    access(1'b0, a, sz, 32'h0, 1'b0);
  endtask

  logic [DIM_W-1:0] width_m, height_m;
  logic [31:0] ctl_m;
  logic [23:0] cpal_m [3];
  logic [15:0] pat_ref [512];

  function automatic logic [31:0] model_word(int t, int k);
    case (t)
      0: return 32'(width_m >> 2);
      1: return 32'(height_m) << 1;
      2: return ctl_m;
      3: return {8'h0, cpal_m[k]};
      4: return {16'h0, pat_ref[k]};
      default: return 32'h10;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h00c0ffee));
    for (int i = 0; i < 512; i++) pat_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // reset state
    chk("R1 ready after reset", 32'(ready), 32'h1);
    chk("R13 irq after reset", 32'(irq), 32'h0);
    chk("R3 width after reset", 32'(width), 32'h0);
    chk("R5 depth after reset", 32'(depth), 32'd1);
    chk("R5 cursor_en after reset", 32'(cursor_en), 32'h1);

    // R2
    rd(21'h000000, 2'd2);
    chk("R1 done in commit cycle", 32'(r_done), 32'h1);
    chk("R2 id read", r_data, 32'h10);
    chk("R2 id no err", 32'(r_err), 32'h0);
    wr(21'h000000, 2'd2, 32'hFFFF_FFFF);
    chk("R2 id write no err", 32'(r_err), 32'h0);
    rd(21'h000000, 2'd2);
    chk("R2 id after write", r_data, 32'h10);
    rd(21'h000001, 2'd0);
    chk("R11 id byte lane1", r_data, 32'h0);
    rd(21'h000000, 2'd0);
    chk("R11 id byte lane0", r_data, 32'h10);

    // R3 / R4
    wr(21'h080118, 2'd2, 32'h50);
    chk("R3 width out", 32'(width), 32'h140);
    rd(21'h080118, 2'd2);
    chk("R3 width read", r_data, 32'h50);
    wr(21'h080118, 2'd2, 32'h4003);
    chk("R3 width truncated", 32'(width), 32'h000C);
    rd(21'h080118, 2'd2);
    chk("R3 width truncated read", r_data, 32'h3);
    wr(21'h080150, 2'd2, 32'h31);
    chk("R4 height out", 32'(height), 32'h18);
    rd(21'h080150, 2'd2);
    chk("R4 height read", r_data, 32'h30);

    // R5
    wr(21'h080300, 2'd2, 32'h00D0_0400);
    chk("R5 depth code5", 32'(depth), 32'd16);
    chk("R5 blank", 32'(blank), 32'h1);
    chk("R5 cursor off", 32'(cursor_en), 32'h0);
    rd(21'h080300, 2'd2);
    chk("R5 ctl readback", r_data, 32'h00D0_0400);
    wr(21'h080300, 2'd2, 32'h0030_0000);
    chk("R5 depth code3", 32'(depth), 32'd8);
    wr(21'h080302, 2'd0, 32'h60);
    chk("R5 R10 depth code6 via byte", 32'(depth), 32'd0);
    rd(21'h080300, 2'd2);
    chk("R10 ctl byte merge", r_data, 32'h0060_0000);

    // R6 cursor colour table
    wr(21'h080510, 2'd2, 32'hAABB_CCDD);
    rd(21'h080514, 2'd2);
    chk("R6 cpal entry1 second word", r_data, 32'h00BB_CCDD);
    chk("R6 cpal out", 32'(cur_pal[47:24]), 32'h00BB_CCDD);
    // colour lookup
    pal_seen = 1'b0;
    wr(21'h080FF8, 2'd2, 32'h1234_5678);
    chk("R6 pal strobe", 32'(pal_seen), 32'h1);
    chk("R6 pal idx", 32'(pal_seen_idx), 32'hFF);
    chk("R6 pal data", 32'(pal_seen_data), 32'h34_5678);
    pal_seen = 1'b0;
    wr(21'h080802, 2'd0, 32'h9A);
    chk("R10 pal byte merge idx", 32'(pal_seen_idx), 32'h0);
    chk("R10 pal byte merge data", 32'(pal_seen_data), 32'h9A_0000);
    rd(21'h080800, 2'd2);
    chk("R12 pal read err", 32'(r_err), 32'h1);
    // bitmap
    wr(21'h081FF8, 2'd2, 32'h0000_BEEF);
    chk("R6 pat stored", 32'(pat_mem[511]), 32'hBEEF);
    wr(21'h081FF8, 2'd0, 32'h11);
    rd(21'h081FF8, 2'd2);
    chk("R10 pat byte merge", r_data, 32'h0000_BE11);
    wr(21'h081FFA, 2'd1, 32'h1234);
    rd(21'h081FF8, 2'd2);
    chk("R10 pat upper half keeps low", r_data, 32'h0000_BE11);
    rd(21'h081FF9, 2'd0);
    chk("R11 pat byte read", r_data, 32'hBE);

    // R7
    wr(21'h080400, 2'd2, 32'h0012_3456);
    chk("R7 top", top, 32'h0012_3456);
    rd(21'h080400, 2'd2);
    chk("R7 top read zero", r_data, 32'h0);
    chk("R12 top read err", 32'(r_err), 32'h1);
    wr(21'h080638, 2'd2, 32'h00AB_C123);
    chk("R7 cursor x", 32'(cx), 32'hABC);
    chk("R7 cursor y", 32'(cy), 32'h123);

    // R8
    wr(21'h080108, 2'd2, 32'hFFFF_FFFF);
    chk("R8 timing write no err", 32'(r_err), 32'h0);
    wr(21'h080200, 2'd2, 32'hFFFF_FFFF);
    chk("R8 timing write no err 200", 32'(r_err), 32'h0);
    chk("R8 width unchanged", 32'(width), 32'h000C);
    rd(21'h080108, 2'd2);
    chk("R12 timing read err", 32'(r_err), 32'h1);

    // R12
    rd(21'h080004, 2'd2);
    chk("R12 undef read zero", r_data, 32'h0);
    chk("R12 undef read err", 32'(r_err), 32'h1);
    wr(21'h080004, 2'd2, 32'h1);
    chk("R12 undef write err", 32'(r_err), 32'h1);
    chk("R12 undef write no effect", 32'(width), 32'h000C);

    // R13
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    chk("R13 irq set", 32'(irq), 32'h1);
    rd(21'h080118, 2'd2);
    chk("R13 read keeps irq", 32'(irq), 32'h1);
    wr(21'h080108, 2'd2, 32'h0);
    chk("R13 write clears irq", 32'(irq), 32'h0);
    access(1'b1, 21'h080108, 2'd2, 32'h0, 1'b1);
    chk("R13 same-edge frame wins", 32'(irq), 32'h1);

    // R9
    clr_seen = 1'b0;
    wr(21'h180000, 2'd2, 32'h0);
    chk("R9 mem clear pulse", 32'(clr_seen), 32'h1);
    chk("R9 width zero", 32'(width), 32'h0);
    chk("R9 height zero", 32'(height), 32'h0);
    chk("R9 top zero", top, 32'h0);
    chk("R9 cursor pos zero", 32'({cx, cy}), 32'h0);
    chk("R9 depth back to 1", 32'(depth), 32'd1);
    rd(21'h080510, 2'd2);
    chk("R9 cpal zero", r_data, 32'h0);
    rd(21'h081FF8, 2'd2);
    chk("R9 pat zero", r_data, 32'h0);

    // constrained random against the model
    width_m = '0; height_m = '0; ctl_m = '0;
    for (int i = 0; i < 3; i++) cpal_m[i] = '0;
    for (int i = 0; i < 512; i++) pat_ref[i] = '0;
    for (int n = 0; n < 400; n++) begin
      int t = int'($urandom % 6);
      int k = 0;
      logic [1:0] sz = 2'($urandom % 3);
      logic [1:0] ln = (sz == 2'd0) ? 2'($urandom % 4) :
                       (sz == 2'd1) ? {1'($urandom % 2), 1'b0} : 2'b00;
      logic [20:0] a;
      logic [31:0] d = $urandom;
      logic w = 1'($urandom % 2);
      case (t)
        0: a = 21'h080118;
        1: a = 21'h080150;
        2: a = 21'h080300;
        3: begin k = int'($urandom % 3); a = 21'h080508 + 21'(8*k) + 21'(4*($urandom % 2)); end
        4: begin k = int'($urandom % 512); a = 21'h081000 + 21'(8*k) + 21'(4*($urandom % 2)); end
        default: a = 21'h000000;
      endcase
      a = a | 21'(ln);
      if (w) begin
        logic [31:0] nw = merge_f(model_word(t, k), d, sz, ln);
        wr(a, sz, d);
        case (t)
          0: width_m = {nw[DIM_W-3:0], 2'b00};
          1: height_m = nw[DIM_W:1];
          2: ctl_m = nw;
          3: cpal_m[k] = nw[23:0];
          4: pat_ref[k] = nw[15:0];
          default: ;
        endcase
        chk("R10 random write no err", 32'(r_err), 32'h0);
      end else begin
        rd(a, sz);
        chk("R11 random read", r_data, extract_f(model_word(t, k), sz, ln));
      end
    end
    chk("R3 random width", 32'(width), 32'(width_m));
    chk("R4 random height", 32'(height), 32'(height_m));
    chk("R5 random blank", 32'(blank), 32'(ctl_m[10]));
    chk("R6 random cpal", 32'(cur_pal[23:0]), 32'(cpal_m[0]));

    finish_run();
  end
endmodule